// File: doc/BRIEF.md
# Descriptor Ring Queue Engine

The block is a per-endpoint queue engine that follows a linked ring of 16-byte transfer descriptors held in memory. Each descriptor has four 32-bit words: word 0 carries flags and, for receive, the allowed buffer length. Word 1 is the address of the next descriptor, word 2 the data buffer address, and word 3 the transfer length field. Software fills a descriptor, sets its ownership bit and starts or resumes the engine. The engine fetches the descriptor and asks the endpoint FIFO side to move data. It then writes the byte count back and clears the ownership bit, which hands the descriptor back to software. Last, it follows the next pointer.

The engine halts on any descriptor it does not own and keeps pointing at it. Software can skip a descriptor by marking it for bypass. A transmit descriptor with zero length is reported as a length error unless zero-length sending is enabled. Stop takes effect at the next descriptor boundary or at once while the engine waits. Memory is reached through a single request/acknowledge word port. Data movement is a length request answered by a done strobe with a byte count.

Top module: `dring_engine`

## Requirements
- R1: After reset `q_active`, `mem_req`, `xfer_req`, `done_pulse` and `lenerr_pulse` are 0 and `cur_desc` is 0.
- R2: A `cmd_start` pulse while inactive loads `cur_desc` from `start_addr` and raises `q_active`. A `cmd_start` while active changes neither `cur_desc` nor the memory traffic.
- R3: A descriptor is fetched with four 32-bit reads at `cur_desc`+0, +4, +8 and +12, in that order.
- R4: If bit 0 (owned) of word 0 is clear, the engine moves no data and writes nothing. It stays active with `cur_desc` on that descriptor, and a later `cmd_resume` fetches the same address again.
- R5: For an owned descriptor, `xfer_len` is taken as follows. For transmit (`dir_rx`=0) it is word 3 bits 15:0, or bits 19:0 when `ext_len`=1. For receive it is word 0 bits 31:16, or bits 31:12 when `ext_len`=1. `xfer_buf` is word 2.
- R6: After the transfer the engine writes word 3 with the returned `xfer_cnt` in bits 15:0 (19:0 in extended mode), keeping the upper bits. It then writes word 0 with bit 0 cleared and all other bits kept, and `cur_desc` becomes word 1.
- R7: `done_pulse` is high for one cycle after the word 0 write-back when bit 7 of word 0 is set, and not at all when bit 7 is clear.
- R8: An owned descriptor with bit 2 (bypass) set moves no data and leaves word 3 unwritten. Word 0 is written with bit 0 cleared, bit 7 still gives `done_pulse`, and the engine advances to word 1.
- R9: An owned transmit descriptor with a zero length field and `zlp_en`=0 raises `lenerr_pulse` for one cycle. It moves no data, writes nothing and halts on that descriptor. With `zlp_en`=1 it completes normally with `xfer_len`=0.
- R10: `cmd_stop` lets the descriptor in progress finish and then drops `q_active` before the next fetch. While halted, it drops `q_active` at once. While inactive there is no memory or transfer request.
- R11: A `cmd_resume` that arrives while active but not halted is held. If the engine then halts on an unowned descriptor, it fetches that descriptor once more on its own. A `cmd_resume` while inactive has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| cmd_resume | input | 1 | Resume command pulse |
| start_addr | input | ADDR_W | Ring start address used by start |
| dir_rx | input | 1 | 1 = receive direction, 0 = transmit |
| ext_len | input | 1 | Extended 20-bit length fields |
| zlp_en | input | 1 | Allow zero-length transmit descriptors |
| q_active | output | 1 | Engine active |
| cur_desc | output | ADDR_W | Descriptor being worked on or waited on |
| mem_req | output | 1 | Memory word request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| xfer_req | output | 1 | Data transfer request, held until done |
| xfer_len | output | LEN_EXT_W | Transfer length in bytes |
| xfer_buf | output | 32 | Buffer address from word 2 |
| xfer_done | input | 1 | Transfer finished |
| xfer_cnt | input | LEN_EXT_W | Bytes moved, valid with `xfer_done` |
| done_pulse | output | 1 | Completion interrupt pulse |
| lenerr_pulse | output | 1 | Zero-length transmit error pulse |

## Verification
The ring is run with transmit descriptors in normal mode and with receive descriptors in both length modes. Upper bits in word 3 and counts that differ from the allowed length show whether the field positions and the merge are right. Unowned, bypass and zero-length descriptors are placed where they test halting and skipping, the error, and the re-fetch at the same address. Command timing is varied to separate these cases: start while active, stop in mid-descriptor against stop while halted, and resume while fetching against resume while inactive.

// File: rtl/dre_pkg.sv
package dre_pkg;
  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int DESC_WORDS = 4;
  localparam int IDX_INFO   = 0;
  localparam int IDX_NEXT   = 1;
  localparam int IDX_BUF    = 2;
  localparam int IDX_LEN    = 3;
  localparam int OWN_BIT    = 0;
  localparam int SKIP_BIT   = 2;
  localparam int IRQ_BIT    = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_NEXT, ST_FETCH, ST_CHECK, ST_MOVE, ST_WB_LEN, ST_WB_FLAG, ST_WAIT
  } walk_st_t;
endpackage

// File: rtl/dre_memseq.sv
module dre_memseq
  import dre_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               fetch_go,
  input  logic                               wr_go,
  input  logic [ADDR_W-1:0]                  base,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [WORD_W-1:0]                  wr_data,
  output logic                               seq_done,
  output logic [DESC_WORDS-1:0][WORD_W-1:0]  words_o,
  output logic                               mem_req,
  output logic                               mem_we,
  output logic [ADDR_W-1:0]                  mem_addr,
  output logic [WORD_W-1:0]                  mem_wdata,
  input  logic                               mem_ack,
  input  logic [WORD_W-1:0]                  mem_rdata
);
  localparam int IDX_W = $clog2(DESC_WORDS);

  logic [IDX_W-1:0] idx;
  logic             rd_beat;

  assign rd_beat = mem_req && mem_ack && !mem_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      idx       <= '0;
      seq_done  <= 1'b0;
    end else begin
      seq_done <= 1'b0;
      if (!mem_req) begin
        if (fetch_go) begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= base;
          idx      <= '0;
        end else if (wr_go) begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= wr_addr;
          mem_wdata <= wr_data;
        end
      end else if (mem_ack) begin
        if (mem_we) begin
          mem_req  <= 1'b0;
          mem_we   <= 1'b0;
          seq_done <= 1'b1;
        end else if (idx == IDX_W'(DESC_WORDS - 1)) begin
          mem_req  <= 1'b0;
          seq_done <= 1'b1;
        end else begin
          idx      <= idx + 1'b1;
          mem_addr <= mem_addr + ADDR_W'(WORD_BYTES);
        end
      end
    end
  end

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_cap
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst) word_q <= '0;
      else if (rd_beat && idx == IDX_W'(g)) word_q <= mem_rdata;
    end
    assign words_o[g] = word_q;
  end
endmodule

// File: rtl/dre_lenfmt.sv
module dre_lenfmt
  import dre_pkg::*;
#(
  parameter int LEN_STD_W = 16,
  parameter int LEN_EXT_W = 20
) (
  input  logic [WORD_W-1:0]    info,
  input  logic [WORD_W-1:0]    lenw,
  input  logic                 dir_rx,
  input  logic                 ext_len,
  input  logic [LEN_EXT_W-1:0] cnt,
  output logic [LEN_EXT_W-1:0] f_len,
  output logic                 f_tx_zero,
  output logic [WORD_W-1:0]    f_len_wb,
  output logic [WORD_W-1:0]    f_info_wb
);
  localparam int TOP = WORD_W - 1;

  logic [LEN_EXT_W-1:0] tx_len, rx_len;

  always_comb begin
    if (ext_len) begin
      tx_len   = lenw[LEN_EXT_W-1:0];
      rx_len   = info[TOP -: LEN_EXT_W];
      f_len_wb = {lenw[TOP:LEN_EXT_W], cnt};
    end else begin
      tx_len   = LEN_EXT_W'(lenw[LEN_STD_W-1:0]);
      rx_len   = LEN_EXT_W'(info[TOP -: LEN_STD_W]);
      f_len_wb = {lenw[TOP:LEN_STD_W], cnt[LEN_STD_W-1:0]};
    end
    f_len     = dir_rx ? rx_len : tx_len;
    f_tx_zero = !dir_rx && (tx_len == '0);
    f_info_wb = info;
    f_info_wb[OWN_BIT] = 1'b0;
  end
endmodule

// File: rtl/dre_walker.sv
module dre_walker
  import dre_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_EXT_W = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_start,
  input  logic                 cmd_stop,
  input  logic                 cmd_resume,
  input  logic [ADDR_W-1:0]    start_addr,
  input  logic                 zlp_en,
  input  logic                 d_own,
  input  logic                 d_skip,
  input  logic                 d_irq,
  input  logic [WORD_W-1:0]    d_next,
  input  logic [LEN_EXT_W-1:0] f_len,
  input  logic                 f_tx_zero,
  input  logic [WORD_W-1:0]    f_len_wb,
  input  logic [WORD_W-1:0]    f_info_wb,
  input  logic                 seq_done,
  input  logic                 xfer_done,
  output logic                 fetch_go,
  output logic                 wr_go,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [WORD_W-1:0]    wr_data,
  output logic [ADDR_W-1:0]    cur,
  output logic                 active,
  output logic                 done_pulse,
  output logic                 lenerr_pulse,
  output logic                 xfer_req,
  output logic [LEN_EXT_W-1:0] xfer_len
);
  localparam int LEN_OFS = IDX_LEN * WORD_BYTES;

  walk_st_t st;
  logic     stop_pend, resume_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_pend   <= 1'b0;
      resume_pend <= 1'b0;
    end else begin
      if (st == ST_IDLE)  stop_pend <= 1'b0;
      else if (cmd_stop)  stop_pend <= 1'b1;

      if (st == ST_IDLE)        resume_pend <= 1'b0;
      else if (cmd_resume)      resume_pend <= 1'b1;
      else if (st == ST_NEXT)   resume_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      cur          <= '0;
      active       <= 1'b0;
      fetch_go     <= 1'b0;
      wr_go        <= 1'b0;
      wr_addr      <= '0;
      wr_data      <= '0;
      done_pulse   <= 1'b0;
      lenerr_pulse <= 1'b0;
      xfer_req     <= 1'b0;
      xfer_len     <= '0;
    end else begin
      fetch_go     <= 1'b0;
      wr_go        <= 1'b0;
      done_pulse   <= 1'b0;
      lenerr_pulse <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cmd_start) begin
            cur    <= start_addr;
            active <= 1'b1;
            st     <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (stop_pend) begin
            active <= 1'b0;
            st     <= ST_IDLE;
          end else begin
            fetch_go <= 1'b1;
            st       <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (seq_done) st <= ST_CHECK;
        end
        ST_CHECK: begin
          if (!d_own) begin
            st <= ST_WAIT;
          end else if (d_skip) begin
            wr_go   <= 1'b1;
            wr_addr <= cur;
            wr_data <= f_info_wb;
            st      <= ST_WB_FLAG;
          end else if (f_tx_zero && !zlp_en) begin
            lenerr_pulse <= 1'b1;
            st           <= ST_WAIT;
          end else begin
            xfer_req <= 1'b1;
            xfer_len <= f_len;
            st       <= ST_MOVE;
          end
        end
        ST_MOVE: begin
          if (xfer_done) begin
            xfer_req <= 1'b0;
            wr_go    <= 1'b1;
            wr_addr  <= cur + ADDR_W'(LEN_OFS);
            wr_data  <= f_len_wb;
            st       <= ST_WB_LEN;
          end
        end
        ST_WB_LEN: begin
          if (seq_done) begin
            wr_go   <= 1'b1;
            wr_addr <= cur;
            wr_data <= f_info_wb;
            st      <= ST_WB_FLAG;
          end
        end
        ST_WB_FLAG: begin
          if (seq_done) begin
            done_pulse <= d_irq;
            cur        <= ADDR_W'(d_next);
            st         <= ST_NEXT;
          end
        end
        ST_WAIT: begin
          if (stop_pend) begin
            active <= 1'b0;
            st     <= ST_IDLE;
          end else if (resume_pend) begin
            st <= ST_NEXT;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dring_engine.sv
module dring_engine
  import dre_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_STD_W = 16,
  parameter int LEN_EXT_W = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_start,
  input  logic                 cmd_stop,
  input  logic                 cmd_resume,
  input  logic [ADDR_W-1:0]    start_addr,
  input  logic                 dir_rx,
  input  logic                 ext_len,
  input  logic                 zlp_en,
  output logic                 q_active,
  output logic [ADDR_W-1:0]    cur_desc,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [31:0]          mem_wdata,
  input  logic                 mem_ack,
  input  logic [31:0]          mem_rdata,
  output logic                 xfer_req,
  output logic [LEN_EXT_W-1:0] xfer_len,
  output logic [31:0]          xfer_buf,
  input  logic                 xfer_done,
  input  logic [LEN_EXT_W-1:0] xfer_cnt,
  output logic                 done_pulse,
  output logic                 lenerr_pulse
);
  logic [DESC_WORDS-1:0][WORD_W-1:0] words;
  logic                 fetch_go, wr_go, seq_done;
  logic [ADDR_W-1:0]    wr_addr;
  logic [WORD_W-1:0]    wr_data;
  logic [LEN_EXT_W-1:0] f_len;
  logic                 f_tx_zero;
  logic [WORD_W-1:0]    f_len_wb, f_info_wb;

  assign xfer_buf = words[IDX_BUF];

  dre_memseq #(.ADDR_W(ADDR_W)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .fetch_go  (fetch_go),
    .wr_go     (wr_go),
    .base      (cur_desc),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .seq_done  (seq_done),
    .words_o   (words),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata)
  );

  dre_lenfmt #(.LEN_STD_W(LEN_STD_W), .LEN_EXT_W(LEN_EXT_W)) fmt_i (
    .info      (words[IDX_INFO]),
    .lenw      (words[IDX_LEN]),
    .dir_rx    (dir_rx),
    .ext_len   (ext_len),
    .cnt       (xfer_cnt),
    .f_len     (f_len),
    .f_tx_zero (f_tx_zero),
    .f_len_wb  (f_len_wb),
    .f_info_wb (f_info_wb)
  );

  dre_walker #(.ADDR_W(ADDR_W), .LEN_EXT_W(LEN_EXT_W)) walk_i (
    .clk          (clk),
    .rst          (rst),
    .cmd_start    (cmd_start),
    .cmd_stop     (cmd_stop),
    .cmd_resume   (cmd_resume),
    .start_addr   (start_addr),
    .zlp_en       (zlp_en),
    .d_own        (words[IDX_INFO][OWN_BIT]),
    .d_skip       (words[IDX_INFO][SKIP_BIT]),
    .d_irq        (words[IDX_INFO][IRQ_BIT]),
    .d_next       (words[IDX_NEXT]),
    .f_len        (f_len),
    .f_tx_zero    (f_tx_zero),
    .f_len_wb     (f_len_wb),
    .f_info_wb    (f_info_wb),
    .seq_done     (seq_done),
    .xfer_done    (xfer_done),
    .fetch_go     (fetch_go),
    .wr_go        (wr_go),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .cur          (cur_desc),
    .active       (q_active),
    .done_pulse   (done_pulse),
    .lenerr_pulse (lenerr_pulse),
    .xfer_req     (xfer_req),
    .xfer_len     (xfer_len)
  );
endmodule

// File: rtl/dre_checker.sv
module dre_checker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_start,
  input logic [ADDR_W-1:0] start_addr,
  input logic              q_active,
  input logic [ADDR_W-1:0] cur_desc,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              xfer_req,
  input logic [LEN_W-1:0]  xfer_len,
  input logic              xfer_done,
  input logic              done_pulse,
  input logic              lenerr_pulse
);
  // R2: start from idle loads the pointer and raises active
  a_r2_start_load: assert property (@(posedge clk) disable iff (rst)
    cmd_start && !q_active |=> q_active && cur_desc == $past(start_addr));

  // R3: a memory request holds address and direction until acknowledged
  a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R5: a transfer request holds its length until done
  a_r5_xfer_hold: assert property (@(posedge clk) disable iff (rst)
    xfer_req && !xfer_done |=> xfer_req && $stable(xfer_len));

  // R6: memory traffic and data movement never overlap
  a_r6_one_owner: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_req, xfer_req}));

  // R7: the completion pulse lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> !done_pulse);

  // R9: a length error moves no data and touches no memory
  a_r9_lenerr_quiet: assert property (@(posedge clk) disable iff (rst)
    lenerr_pulse |-> !xfer_req && !mem_req);

  // R10: an inactive engine issues no requests
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !q_active |-> !mem_req && !xfer_req);
endmodule

bind dring_engine dre_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_EXT_W)) chk_i (.*);

// File: tb/dring_engine_tb_top.sv
module dring_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int LW = 20;
  localparam int EV_RD = 0, EV_WR = 1, EV_XF = 2, EV_DONE = 3, EV_LERR = 4;

  typedef struct {
    int          kind;
    logic [31:0] a;
    logic [31:0] d;
    string       tag;
  } ev_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_start = 0, cmd_stop = 0, cmd_resume = 0;
  logic [AW-1:0] start_addr = '0;
  logic dir_rx = 0, ext_len = 0, zlp_en = 0;
  logic q_active, mem_req, mem_we, xfer_req, done_pulse, lenerr_pulse;
  logic [AW-1:0] cur_desc, mem_addr;
  logic [31:0] mem_wdata, xfer_buf;
  logic mem_ack = 0;
  logic [31:0] mem_rdata = '0;
  logic [LW-1:0] xfer_len;
  logic xfer_done = 0;
  logic [LW-1:0] xfer_cnt = '0;
  logic [LW-1:0] rx_cnt = '0;

  logic [31:0] mem [64];
  ev_t exq[$];
  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dring_engine dut_i (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_resume(cmd_resume), .start_addr(start_addr), .dir_rx(dir_rx),
    .ext_len(ext_len), .zlp_en(zlp_en), .q_active(q_active), .cur_desc(cur_desc),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .xfer_req(xfer_req), .xfer_len(xfer_len),
    .xfer_buf(xfer_buf), .xfer_done(xfer_done), .xfer_cnt(xfer_cnt),
    .done_pulse(done_pulse), .lenerr_pulse(lenerr_pulse)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic observe(input int kind, input logic [31:0] a, input logic [31:0] d);
    ev_t e;
    n_cmp++;
    if (exq.size() == 0) begin
      n_bad++;
      $display("FAIL unexpected event: actual kind=%0d a=%h d=%h expected none", kind, a, d);
    end else begin
      e = exq.pop_front();
      if (e.kind != kind || e.a != a || e.d != d) begin
        n_bad++;
        $display("FAIL %s actual kind=%0d a=%h d=%h expected kind=%0d a=%h d=%h",
                 e.tag, kind, a, d, e.kind, e.a, e.d);
      end
    end
  endtask

  // memory slave, FIFO model and monitor
  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 0;
      xfer_done = 0;
    end else begin
      if (mem_ack) mem_ack = 0;
      else if (mem_req) begin
        if (mem_we) begin
          mem[mem_addr[7:2]] = mem_wdata;
          observe(EV_WR, mem_addr, mem_wdata);
        end else begin
          mem_rdata = mem[mem_addr[7:2]];
          observe(EV_RD, mem_addr, 32'h0);
        end
        mem_ack = 1;
      end
      if (xfer_done) xfer_done = 0;
      else if (xfer_req) begin
        observe(EV_XF, 32'(xfer_len), 32'h0);
        xfer_cnt = dir_rx ? rx_cnt : xfer_len;
        xfer_done = 1;
      end
      if (done_pulse) observe(EV_DONE, 0, 0);
      if (lenerr_pulse) observe(EV_LERR, 0, 0);
    end
  end

  task automatic push(input int kind, input logic [31:0] a, input logic [31:0] d, input string tag);
    ev_t e;
    e.kind = kind; e.a = a; e.d = d; e.tag = tag;
    exq.push_back(e);
  endtask

  task automatic set_desc(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] w2, input logic [31:0] w3);
    mem[a[7:2]] = w0; mem[a[7:2]+1] = w1; mem[a[7:2]+2] = w2; mem[a[7:2]+3] = w3;
  endtask

  // R3: four word reads in order
  task automatic exp_fetch(input logic [31:0] a);
    for (int i = 0; i < 4; i++) push(EV_RD, a + 32'(4*i), 0, "R3");
  endtask

  // R5/R6/R7: full completion of an owned descriptor
  task automatic exp_complete(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w3,
                              input logic [31:0] len, input logic [31:0] cnt);
    logic [31:0] wb;
    exp_fetch(a);
    push(EV_XF, len, 0, "R5");
    wb = ext_len ? {w3[31:20], cnt[19:0]} : {w3[31:16], cnt[15:0]};
    push(EV_WR, a + 32'd12, wb, "R6");
    push(EV_WR, a, w0 & ~32'h1, "R6");
    if (w0[7]) push(EV_DONE, 0, 0, "R7");
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) cmd_start = 1; else if (which == 1) cmd_stop = 1; else cmd_resume = 1;
    @(negedge clk);
    cmd_start = 0; cmd_stop = 0; cmd_resume = 0;
  endtask

  task automatic drain(input string tag);
    int t = 0;
    while (exq.size() != 0 && t < 3000) begin @(negedge clk); t++; end
    if (exq.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL %s pending events actual=%0d expected=0", tag, exq.size());
      exq.delete();
    end
    repeat (20) @(negedge clk);
  endtask

  task automatic stop_all();
    pulse(1);
    repeat (5) @(negedge clk);
    chk(q_active == 0, "R10 stop from halt", 32'(q_active), 0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk(q_active == 0 && mem_req == 0 && xfer_req == 0, "R1 idle outputs",
        {29'b0, q_active, mem_req, xfer_req}, 0);
    chk(done_pulse == 0 && lenerr_pulse == 0, "R1 pulses", {30'b0, done_pulse, lenerr_pulse}, 0);
    chk(cur_desc == 0, "R1 cur_desc", cur_desc, 0);

    // Transmit, normal length mode
    set_desc(32'h40, 32'h81, 32'h50, 32'h1000, 32'h0000_0005);
    set_desc(32'h50, 32'h01, 32'h60, 32'h2000, 32'hABCD_1234);
    set_desc(32'h60, 32'h80, 32'h40, 32'h3000, 32'h0000_0007);
    exp_complete(32'h40, 32'h81, 32'h0000_0005, 32'h5, 32'h5);
    exp_complete(32'h50, 32'h01, 32'hABCD_1234, 32'h1234, 32'h1234);
    exp_fetch(32'h60);
    start_addr = 32'h40;
    pulse(0);
    drain("R6 tx ring");
    chk(q_active == 1, "R4 halted stays active", 32'(q_active), 1);
    chk(cur_desc == 32'h60, "R4 halted pointer", cur_desc, 32'h60);
    // R2: start while active is ignored
    start_addr = 32'h00;
    pulse(0);
    drain("R2 start ignored");
    chk(cur_desc == 32'h60, "R2 start while active", cur_desc, 32'h60);
    // R4: resume refetches the halted descriptor, ring wraps to a returned one
    mem[32'h60 >> 2] = 32'h81;
    exp_complete(32'h60, 32'h81, 32'h0000_0007, 32'h7, 32'h7);
    exp_fetch(32'h40);
    pulse(2);
    drain("R4 resume");
    chk(cur_desc == 32'h40, "R4 wrap halt", cur_desc, 32'h40);
    stop_all();
    // R11: resume while inactive ignored
    pulse(2);
    drain("R11 resume idle");
    chk(q_active == 0, "R11 resume while inactive", 32'(q_active), 0);

    // Receive, extended mode
    dir_rx = 1; ext_len = 1; rx_cnt = 20'h00ABC;
    set_desc(32'h80, 32'h1234_5081, 32'h90, 32'h4000, 32'hF000_0000);
    set_desc(32'h90, 32'h0, 32'h80, 32'h0, 32'h0);
    exp_complete(32'h80, 32'h1234_5081, 32'hF000_0000, 32'h12345, 32'h00ABC);
    exp_fetch(32'h90);
    start_addr = 32'h80;
    pulse(0);
    drain("R5 rx ext");
    chk(mem[32'h8C >> 2] == 32'hF000_0ABC, "R6 rx ext merge", mem[32'h8C >> 2], 32'hF000_0ABC);
    stop_all();

    // Receive, normal mode, no interrupt flag
    ext_len = 0; rx_cnt = 20'h001FF;
    set_desc(32'hA0, 32'h0200_0001, 32'hB0, 32'h5000, 32'h5555_0000);
    set_desc(32'hB0, 32'h0, 32'hA0, 32'h0, 32'h0);
    exp_complete(32'hA0, 32'h0200_0001, 32'h5555_0000, 32'h200, 32'h1FF);
    exp_fetch(32'hB0);
    start_addr = 32'hA0;
    pulse(0);
    drain("R7 no irq");
    stop_all();

    // R9 then R8: zero-length transmit error, then bypass
    dir_rx = 0;
    set_desc(32'hC0, 32'h81, 32'hD0, 32'h6000, 32'h1234_0000);
    set_desc(32'hD0, 32'h0, 32'hC0, 32'h0, 32'h0);
    exp_fetch(32'hC0);
    push(EV_LERR, 0, 0, "R9");
    start_addr = 32'hC0;
    pulse(0);
    drain("R9 lenerr");
    chk(cur_desc == 32'hC0, "R9 halt on error", cur_desc, 32'hC0);
    chk(mem[32'hCC >> 2] == 32'h1234_0000, "R9 no writeback", mem[32'hCC >> 2], 32'h1234_0000);
    mem[32'hC0 >> 2] = 32'h85;
    exp_fetch(32'hC0);
    push(EV_WR, 32'hC0, 32'h84, "R8");
    push(EV_DONE, 0, 0, "R8");
    exp_fetch(32'hD0);
    pulse(2);
    drain("R8 bypass");
    chk(cur_desc == 32'hD0, "R8 advanced", cur_desc, 32'hD0);
    chk(mem[32'hCC >> 2] == 32'h1234_0000, "R8 length untouched", mem[32'hCC >> 2], 32'h1234_0000);
    stop_all();

    // R9: zero length allowed when enabled
    zlp_en = 1;
    set_desc(32'hE0, 32'h81, 32'hF0, 32'h7000, 32'h0);
    set_desc(32'hF0, 32'h0, 32'hE0, 32'h0, 32'h0);
    exp_complete(32'hE0, 32'h81, 32'h0, 32'h0, 32'h0);
    exp_fetch(32'hF0);
    start_addr = 32'hE0;
    pulse(0);
    drain("R9 zlp enabled");
    stop_all();
    zlp_en = 0;

    // R11: resume during a fetch is held and causes one refetch
    exp_fetch(32'hF0);
    exp_fetch(32'hF0);
    start_addr = 32'hF0;
    pulse(0);
    repeat (2) @(negedge clk);
    pulse(2);
    drain("R11 held resume");
    chk(q_active == 1 && cur_desc == 32'hF0, "R11 halted after refetch", cur_desc, 32'hF0);
    stop_all();

    // R10: stop during a fetch finishes that descriptor only
    set_desc(32'h00, 32'h81, 32'h10, 32'h8000, 32'h3);
    set_desc(32'h10, 32'h81, 32'h00, 32'h9000, 32'h4);
    exp_complete(32'h00, 32'h81, 32'h3, 32'h3, 32'h3);
    start_addr = 32'h00;
    pulse(0);
    repeat (2) @(negedge clk);
    pulse(1);
    drain("R10 stop mid");
    chk(q_active == 0, "R10 inactive after finish", 32'(q_active), 0);
    chk(cur_desc == 32'h10, "R10 pointer at next", cur_desc, 32'h10);
    chk(mem[32'h10 >> 2] == 32'h81, "R10 next untouched", mem[32'h10 >> 2], 32'h81);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule